// File: doc/BRIEF.md
# Character Display Register Port

This block is the host-facing side of a character display controller. The host sees a 2 KB address window. Only address bit 0 is decoded, so the window holds just two registers, each repeated throughout it. Every even offset reaches the control/status register. Every odd offset reaches the data register.

Reading the control register returns a status byte. Its top bit flags that the controller is still working, and its low seven bits hold the display memory pointer. Writing the control register issues a command; the only command acted upon loads the pointer. Data register accesses read or write one byte of a 128-entry display memory at the pointer, and the pointer then steps forward. Each accepted command or data access keeps the controller busy for a fixed number of cycles. Any command or data access arriving in that time is discarded.

Read results are registered. The byte from a status or data read appears on `rd_data` one clock after the access and stays there until the next accepted read.

Top module: `lcd_regif`

## Requirements
- R1: Only address bit 0 selects the register (0 = control/status, 1 = data); all higher address bits are ignored.
- R2: A status read is always performed, busy or not. One cycle later, `rd_data` holds the busy flag in bit 7 and the pointer in bits 6..0, both as they stood when the read was made.
- R3: A command write with bit 7 set, made while not busy, loads the pointer from the command's bits 6..0.
- R4: A command write with bit 7 clear, made while not busy, leaves the pointer unchanged but still starts the busy period.
- R5: A data write made while not busy stores the byte at the pointer, then increments the pointer.
- R6: A data read made while not busy returns the byte at the pointer on `rd_data` one cycle later, then increments the pointer.
- R7: After each accepted command or data access, the busy flag reads 1 for exactly BUSY_CYCLES consecutive cycles and then reads 0; status reads do not extend it.
- R8: A command or data access made while busy is discarded: memory, pointer and `rd_data` are all left unchanged.
- R9: The pointer wraps from 127 to 0 on increment.
- R10: After reset the pointer is 0, the block is not busy and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (11) | Offset inside the display window |
| acc_wdata | input | DATA_W (8) | Command or data byte to write |
| rd_data | output | DATA_W (8) | Registered result of the last status or accepted data read |

## Verification
The hardest case to reach from the ports is an access that is discarded. It leaves no visible trace, so its effect can only be seen later, by reading back the state it might have touched. The stimulus issues data writes, data reads and commands back to back while busy is still set. It then waits for the busy period to end, repositions the pointer, and reads back the neighbouring memory bytes and the status byte. The exact length of the busy window is confirmed by a run of status reads, one per cycle, that starts right after an accepted access.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;

    // Kind of host access after address decode
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_STATUS,
        ACC_CMD,
        ACC_DWR,
        ACC_DRD
    } acc_kind_e;

endpackage

// File: rtl/lcd_addr_decode.sv
module lcd_addr_decode
    import lcd_regif_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind
);

    // Upper offset bits alias: the whole window folds onto two registers
    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:1];

    always_comb begin
        kind = ACC_NONE;
        if (valid) begin
            if (addr[0]) begin
                kind = write ? ACC_DWR : ACC_DRD;
            end else begin
                kind = write ? ACC_CMD : ACC_STATUS;
            end
        end
    end

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
    import lcd_regif_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data
);

    // Status byte is {busy, pointer}, so the pointer takes the remaining bits
    localparam int PTR_W = DATA_W - 1;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t             st_d, st_q;
    acc_kind_e         kind;
    logic              busy;
    logic              timer_start;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;
    logic [PTR_W-1:0]  ptr_q;

    lcd_addr_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .valid (acc_valid),
        .write (acc_write),
        .addr  (acc_addr),
        .kind  (kind)
    );

    lcd_busy_timer #(
        .CYCLES (BUSY_CYCLES)
    ) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (timer_start),
        .busy  (busy)
    );

    lcd_disp_ram #(
        .AW (PTR_W),
        .DW (DATA_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (st_q.ptr),
        .wdata (acc_wdata),
        .rdata (ram_rdata)
    );

    always_comb begin
        st_d        = st_q;
        ram_we      = 1'b0;
        timer_start = 1'b0;
        unique case (kind)
            ACC_STATUS: begin
                st_d.rdata = {busy, st_q.ptr};
            end
            ACC_CMD: begin
                if (!busy) begin
                    timer_start = 1'b1;
                    if (acc_wdata[DATA_W-1]) begin
                        st_d.ptr = acc_wdata[PTR_W-1:0];
                    end
                end
            end
            ACC_DWR: begin
                if (!busy) begin
                    timer_start = 1'b1;
                    ram_we      = 1'b1;
                    st_d.ptr    = st_q.ptr + 1'b1;
                end
            end
            ACC_DRD: begin
                if (!busy) begin
                    timer_start = 1'b1;
                    st_d.rdata  = ram_rdata;
                    st_d.ptr    = st_q.ptr + 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;
    assign ptr_q   = st_q.ptr;

endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-2:0] ptr,
    input logic              busy
);

    localparam int PTR_W = DATA_W - 1;
    localparam logic [PTR_W-1:0] PTR_MAX = '1;

    logic is_cmd, is_data, is_status;
    assign is_cmd    = acc_valid && acc_write && !acc_addr[0];
    assign is_status = acc_valid && !acc_write && !acc_addr[0];
    assign is_data   = acc_valid && acc_addr[0];

    // R1, R2: any even offset reads status as it stood at the access
    a_r2_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        is_status |=> rd_data == {$past(busy), $past(ptr)});

    a_r3_cmd_loads_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd && !busy && acc_wdata[DATA_W-1] |=> ptr == $past(acc_wdata[PTR_W-1:0]));

    a_r4_cmd_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd && !busy && !acc_wdata[DATA_W-1] |=> $stable(ptr) && busy);

    a_r5_data_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        is_data && !busy && ptr != PTR_MAX |=> ptr == $past(ptr) + 1'b1);

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd || is_data) && !busy |=> busy);

    a_r8_drop_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd || is_data) && busy |=> $stable(ptr) && $stable(rd_data));

    a_r9_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        is_data && !busy && ptr == PTR_MAX |=> ptr == '0);

endmodule

bind lcd_regif lcd_regif_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .rd_data   (rd_data),
    .ptr       (ptr_q),
    .busy      (busy)
);

// File: tb/lcd_regif_bench.sv
module lcd_regif_bench;

    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [10:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;
    string cur_req = "R10";

    always #10 clk = ~clk;

    lcd_regif #(
        .ADDR_W      (11),
        .DATA_W      (8),
        .BUSY_CYCLES (BUSY)
    ) u_lcd_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .rd_data   (rd_data)
    );

    // Behavioural reference model
    int         m_ptr;
    int         m_cnt;
    logic [7:0] m_rdata;
    logic [7:0] m_mem [128];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr   = 0;
            m_cnt   = 0;
            m_rdata = 8'h00;
        end else begin
            bit b;
            int nxt;
            b   = (m_cnt != 0);
            nxt = b ? m_cnt - 1 : 0;
            if (acc_valid) begin
                if (acc_addr[0] == 1'b0) begin
                    if (!acc_write) begin
                        m_rdata = {b, 7'(m_ptr)};
                    end else if (!b) begin
                        if (acc_wdata[7]) m_ptr = int'(acc_wdata[6:0]);
                        nxt = BUSY;
                    end
                end else if (!b) begin
                    if (acc_write) m_mem[m_ptr] = acc_wdata;
                    else           m_rdata = m_mem[m_ptr];
                    m_ptr = (m_ptr + 1) % 128;
                    nxt = BUSY;
                end
            end
            m_cnt = nxt;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rd_data !== m_rdata) begin
                bad++;
                $display("FAIL %s model compare: actual=%02h expected=%02h", cur_req, rd_data, m_rdata);
            end
        end
    end

    function automatic logic [7:0] pat(int i);
        return 8'((i * 29 + 3) & 255);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the access edge
    task automatic acc(logic w, logic [10:0] a, logic [7:0] d);
        acc_valid = 1'b1;
        acc_write = w;
        acc_addr  = a;
        acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic status(logic [10:0] a, output logic [7:0] s);
        acc(1'b0, a, 8'h00);
        s = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL R7 watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 rd_data after reset", rd_data, 8'h00);
        status(11'h000, s);
        check("R10 status after reset", s, 8'h00);

        // R5 / R1: fill memory through scattered odd offsets
        cur_req = "R5";
        for (int i = 0; i < 128; i++) begin
            acc(1'b1, 11'((i * 6 + 1) & 11'h7FF), pat(i));
            idle(BUSY);
        end
        status(11'h7FE, s);
        check("R9 pointer wrapped after 128 writes, R1 alias 7FE", s, 8'h00);

        // R3 and R7: load pointer, busy visible at once
        cur_req = "R3";
        acc(1'b1, 11'h2A4, 8'h85);
        status(11'h000, s);
        check("R7 busy right after command", s, 8'h85);
        idle(BUSY);
        status(11'h41C, s);
        check("R3 pointer loaded", s, 8'h05);

        // R4: other command ignored
        cur_req = "R4";
        acc(1'b1, 11'h100, 8'h12);
        idle(BUSY);
        status(11'h000, s);
        check("R4 pointer kept", s, 8'h05);

        // R6: data read
        cur_req = "R6";
        acc(1'b0, 11'h001, 8'h00);
        check("R6 read data", rd_data, pat(5));
        status(11'h000, s);
        check("R6 pointer stepped, busy", s, 8'h86);
        idle(BUSY);
        status(11'h000, s);
        check("R6 pointer after read", s, 8'h06);

        // R8: write during busy discarded
        cur_req = "R8";
        acc(1'b1, 11'h7FF, 8'hEE);
        acc(1'b1, 11'h003, 8'h11);
        idle(BUSY);
        status(11'h000, s);
        check("R8 pointer after dropped write", s, 8'h07);
        acc(1'b1, 11'h000, 8'h86);
        idle(BUSY);
        acc(1'b0, 11'h0F1, 8'h00);
        check("R5 written byte", rd_data, 8'hEE);
        idle(BUSY);
        acc(1'b0, 11'h001, 8'h00);
        check("R8 memory untouched by dropped write", rd_data, pat(7));
        idle(BUSY);

        // R8: read during busy discarded
        acc(1'b0, 11'h001, 8'h00);
        acc(1'b0, 11'h003, 8'h00);
        check("R8 rd_data kept on dropped read", rd_data, pat(8));
        idle(BUSY);
        status(11'h000, s);
        check("R8 pointer after dropped read", s, 8'h09);

        // R8: command during busy discarded
        acc(1'b0, 11'h001, 8'h00);
        acc(1'b1, 11'h000, 8'hC0);
        idle(BUSY);
        status(11'h000, s);
        check("R8 pointer after dropped command", s, 8'h0A);

        // R7: busy length, status reads do not extend it
        cur_req = "R7";
        acc(1'b1, 11'h000, 8'h00);
        for (int k = 1; k <= BUSY + 1; k++) begin
            status(11'h000, s);
            check("R7 busy window", s, (k <= BUSY) ? 8'h8A : 8'h0A);
        end

        // R9: wrap at top of memory
        cur_req = "R9";
        acc(1'b1, 11'h000, 8'hFF);
        idle(BUSY);
        acc(1'b1, 11'h005, 8'h5A);
        idle(BUSY);
        status(11'h000, s);
        check("R9 pointer wrapped", s, 8'h00);
        acc(1'b1, 11'h000, 8'hFF);
        idle(BUSY);
        acc(1'b0, 11'h7FF, 8'h00);
        check("R9 top byte", rd_data, 8'h5A);
        idle(BUSY);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule